// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register File

This block is the message-signalled interrupt capability of a PCI function's configuration space. It decodes configuration reads and writes that land in the capability window. Each write carries a byte-enable mask, and every register bit carries a write mask. The block holds the message control word, the message address (low word, and a high word when 64-bit addressing is built in) and the 16-bit message data. When per-vector masking is built in, it also holds a per-vector mask word and a pending word. The interrupt dispatcher beside it reads the decoded state from dedicated outputs. These are the enable bit, the log2 of the allocated vector count, the full message address, the data, the mask and the pending bits.

Two build options change the layout: 64-bit addressing and per-vector masking. The supported vector count is a third option, and it fixes the read-only "capable" field. Some writes overlap the capability while the enable bit ends up set. Each such write has three side effects. A vector request larger than the capable value is clamped down to it. Pending bits at or above the enabled vector count are dropped. A one-cycle pulse asks the legacy INTx logic to release its line. The dispatcher records undeliverable vectors through a set input and retires them through a clear input.

Top module: `msi_cap_regs`

## Requirements
- R1: The header dword at the capability base reads capability ID 0x05 in bits 7:0 and the next pointer in bits 15:8. The dwords that follow are, in order: address low, address high (only when 64-bit), data in bits 15:0, mask and pending (only with masking). The capability spans 0x0A, 0x0E, 0x14 or 0x18 bytes for 32-bit, 64-bit, 32-bit with masking and 64-bit with masking.
- R2: The message control word occupies header bits 31:16. In control bit terms: bit 0 is enable, bits 3:1 are the capable field (log2 of the vector count), bits 6:4 are the requested field, bit 7 is 1 for 64-bit addressing and bit 8 is 1 when masking is present. Only bit 0 and bits 6:4 accept writes.
- R3: Address low bits 1:0 always read 0. Address high is writable in all 32 bits. Message data is writable in bits 15:0, and its bits 31:16 read 0.
- R4: A write changes only the bytes whose byte-enable bit is 1. Each of those bytes becomes (old & ~wmask) | (new & wmask).
- R5: Only mask bits 0 to N-1 are writable, where N is the supported vector count. All higher mask bits read 0.
- R6: A write that overlaps the capability and leaves enable at 1 with a requested field above the capable field stores the capable value instead. With enable at 0, the requested field is stored as written.
- R7: In the cycle after any overlapping write that leaves enable at 1, intx_deassert is high for exactly one cycle. It stays low otherwise.
- R8: pend_set sets pending bits below N and pend_clr clears pending bits, with clear winning over set. Configuration writes never change the pending word.
- R9: Reset clears enable, the requested field, address low and high, data, mask, pending and intx_deassert.
- R10: A write in which no enabled byte falls inside the capability span changes no register and raises no pulse. This covers the reserved upper data bytes inside the span. Reads outside the span return 0.
- R11: On an overlapping write that leaves enable at 1, pending bits at or above 2^(requested field after clamping) are cleared. This includes bits raised by pend_set in the same cycle. With enable at 0, no trim happens.
- R12: msi_enable, vec_count_log2, msg_addr (high word 0 when 32-bit), msg_data, vec_mask and vec_pending follow the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | CFG_DW_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, 0 when not reading a capability dword |
| pend_set | input | 32 | Dispatcher marks vectors pending |
| pend_clr | input | 32 | Dispatcher retires pending vectors |
| msi_enable | output | 1 | Enable bit |
| vec_count_log2 | output | 3 | Requested (allocated) vector count, log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pending | output | 32 | Per-vector pending bits |
| intx_deassert | output | 1 | One-cycle request to release legacy INTx |

## Verification
A configuration write and a dispatcher pend_set can land in the same cycle. The trim of R11 and the set of R8 then compete for the same pending bits. The bench provokes this by driving pend_set on a vector above the enabled count during a write to the data dword while enable is 1. It expects the new bit to be dropped, the older in-range bit to survive, and intx_deassert to pulse. A second write to a reserved byte of the data dword is also checked. It must trigger the same trim and pulse, and leave the data unchanged.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

  localparam int VEC_W = 32;
  localparam logic [7:0] MSI_CAP_ID = 8'h05;
  // writable header bits: control enable (bit 16) and requested field (22:20)
  localparam logic [31:0] HDR_WMASK = 32'h0071_0000;
  localparam logic [31:0] ALO_WMASK = 32'hFFFF_FFFC;
  localparam logic [31:0] DATA_WMASK = 32'h0000_FFFF;

  typedef enum logic [2:0] {
    SLOT_NONE, SLOT_HDR, SLOT_ALO, SLOT_AHI, SLOT_DATA, SLOT_MASK, SLOT_PEND
  } slot_e;

  function automatic logic [8:0] cap_len(bit a64, bit pvm);
    case ({a64, pvm})
      2'b00:   return 9'h0A;
      2'b10:   return 9'h0E;
      2'b01:   return 9'h14;
      default: return 9'h18;
    endcase
  endfunction

  // dword index inside the window -> register slot, per build option
  function automatic slot_e slot_of(logic [2:0] rel, bit a64, bit pvm);
    case (rel)
      3'd0: return SLOT_HDR;
      3'd1: return SLOT_ALO;
      3'd2: return a64 ? SLOT_AHI : SLOT_DATA;
      3'd3: return a64 ? SLOT_DATA : (pvm ? SLOT_MASK : SLOT_NONE);
      3'd4: return pvm ? (a64 ? SLOT_MASK : SLOT_PEND) : SLOT_NONE;
      3'd5: return (a64 && pvm) ? SLOT_PEND : SLOT_NONE;
      default: return SLOT_NONE;
    endcase
  endfunction

  function automatic logic [31:0] merge_bytes(logic [31:0] old_v, logic [31:0] new_v,
                                              logic [31:0] wm, logic [3:0] be);
    logic [31:0] r;
    r = old_v;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = (old_v[8*i +: 8] & ~wm[8*i +: 8]) | (new_v[8*i +: 8] & wm[8*i +: 8]);
    return r;
  endfunction

  // ones in bits 0..n-1
  function automatic logic [31:0] low_ones(int n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << n) - 32'h1;
  endfunction

  // pending bits kept for a log2 vector count
  function automatic logic [31:0] vec_window(logic [2:0] lg);
    return low_ones(1 << lg);
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
`timescale 1ns/1ps
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int CFG_DW_W = 6,
  parameter logic [CFG_DW_W-1:0] CAP_BASE_DW = 6'h14,
  parameter bit ADDR64 = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1
) (
  input  logic [CFG_DW_W-1:0] dw_addr,
  input  logic [3:0]          be,
  output slot_e               slot,
  output logic                overlap
);
  localparam int BYTE_W = CFG_DW_W + 3;
  localparam logic [BYTE_W-1:0] BASE_B = BYTE_W'({CAP_BASE_DW, 2'b00});
  localparam logic [BYTE_W-1:0] END_B = BASE_B + BYTE_W'(cap_len(ADDR64, PER_VEC_MASK));

  logic [CFG_DW_W-1:0] rel;
  logic [3:0]          in_span;

  assign rel  = dw_addr - CAP_BASE_DW;
  assign slot = (dw_addr >= CAP_BASE_DW && rel < CFG_DW_W'(6)) ?
                slot_of(rel[2:0], ADDR64, PER_VEC_MASK) : SLOT_NONE;

  for (genvar i = 0; i < 4; i++) begin : g_byte
    logic [BYTE_W-1:0] baddr;
    assign baddr = BYTE_W'({dw_addr, 2'(i)});
    assign in_span[i] = (baddr >= BASE_B) && (baddr < END_B);
  end

  assign overlap = |(be & in_span);
endmodule

// File: rtl/msi_cap_ctrl.sv
`timescale 1ns/1ps
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  parameter logic [2:0] MMC = 3'd3,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_wr,
  input  logic        hdr_wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        enable,
  output logic [2:0]  mme,
  output logic [2:0]  mme_next,
  output logic        side_fx,
  output logic        intx_pulse,
  output logic [31:0] hdr_dword
);
  logic [31:0] merged;
  logic        en_w;
  logic [2:0]  mme_w;
  logic        unused_hdr;

  assign hdr_dword = {7'b0, PER_VEC_MASK, ADDR64, mme, MMC, enable, NEXT_PTR, MSI_CAP_ID};
  assign merged    = merge_bytes(hdr_dword, wdata, HDR_WMASK, be);
  assign unused_hdr = ^{merged[31:23], merged[19:17], merged[15:0]};

  assign en_w     = hdr_wr ? merged[16] : enable;
  assign mme_w    = hdr_wr ? merged[22:20] : mme;
  assign side_fx  = cap_wr & en_w;
  assign mme_next = (side_fx && mme_w > MMC) ? MMC : mme_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      mme        <= 3'd0;
      intx_pulse <= 1'b0;
    end else begin
      if (cap_wr) begin
        enable <= en_w;
        mme    <= mme_next;
      end
      intx_pulse <= side_fx;
    end
  end

  assert_mme_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (mme <= MMC));
  assert_intx_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intx_pulse |-> enable);
  assert_intx_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    intx_pulse |-> $past(cap_wr));
endmodule

// File: rtl/msi_cap_vec.sv
`timescale 1ns/1ps
module msi_cap_vec
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter bit PER_VEC_MASK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic [VEC_W-1:0] pend_set,
  input  logic [VEC_W-1:0] pend_clr,
  input  logic             side_fx,
  input  logic [2:0]       mme_next,
  output logic [VEC_W-1:0] mask,
  output logic [VEC_W-1:0] pending
);
  localparam logic [31:0] VEC_WM = low_ones(NUM_VEC);

  if (PER_VEC_MASK) begin : g_pvm
    logic [VEC_W-1:0] pend_raw;
    assign pend_raw = (pending | (pend_set & VEC_WM)) & ~pend_clr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask    <= '0;
        pending <= '0;
      end else begin
        if (mask_wr) mask <= merge_bytes(mask, wdata, VEC_WM, be);
        pending <= side_fx ? (pend_raw & vec_window(mme_next)) : pend_raw;
      end
    end

    assert_mask_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask & ~VEC_WM) == '0);
    assert_pend_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending & ~VEC_WM) == '0);
    assert_trim_R11: assert property (@(posedge clk) disable iff (!rst_n)
      side_fx |=> ((pending & ~vec_window($past(mme_next))) == '0));
  end else begin : g_nopvm
    logic unused_vec;
    assign unused_vec = ^{mask_wr, be, wdata, pend_set, pend_clr, side_fx, mme_next, clk, rst_n};
    assign mask    = '0;
    assign pending = '0;
  end
endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int CFG_DW_W = 6,
  parameter logic [CFG_DW_W-1:0] CAP_BASE_DW = 6'h14,
  parameter logic [7:0] NEXT_PTR = 8'h00,
  parameter bit ADDR64 = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  parameter int NUM_VEC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [CFG_DW_W-1:0] cfg_dw_addr,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [31:0]         pend_set,
  input  logic [31:0]         pend_clr,
  output logic                msi_enable,
  output logic [2:0]          vec_count_log2,
  output logic [63:0]         msg_addr,
  output logic [15:0]         msg_data,
  output logic [31:0]         vec_mask,
  output logic [31:0]         vec_pending,
  output logic                intx_deassert
);
  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  slot_e       slot;
  logic        overlap, cap_wr, side_fx;
  logic [2:0]  mme_next;
  logic [31:0] hdr_dword, addr_lo, addr_hi;
  logic [15:0] data_q;
  logic [31:0] rd_mux;

  msi_cap_decode #(
    .CFG_DW_W(CFG_DW_W), .CAP_BASE_DW(CAP_BASE_DW),
    .ADDR64(ADDR64), .PER_VEC_MASK(PER_VEC_MASK)
  ) u_decode (
    .dw_addr(cfg_dw_addr), .be(cfg_be), .slot(slot), .overlap(overlap)
  );

  assign cap_wr = cfg_wr & overlap;

  msi_cap_ctrl #(
    .ADDR64(ADDR64), .PER_VEC_MASK(PER_VEC_MASK), .MMC(MMC), .NEXT_PTR(NEXT_PTR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .hdr_wr(cap_wr && slot == SLOT_HDR),
    .be(cfg_be), .wdata(cfg_wdata), .enable(msi_enable), .mme(vec_count_log2),
    .mme_next(mme_next), .side_fx(side_fx), .intx_pulse(intx_deassert),
    .hdr_dword(hdr_dword)
  );

  msi_cap_vec #(.NUM_VEC(NUM_VEC), .PER_VEC_MASK(PER_VEC_MASK)) u_vec (
    .clk(clk), .rst_n(rst_n), .mask_wr(cap_wr && slot == SLOT_MASK),
    .be(cfg_be), .wdata(cfg_wdata), .pend_set(pend_set), .pend_clr(pend_clr),
    .side_fx(side_fx), .mme_next(mme_next), .mask(vec_mask), .pending(vec_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      data_q  <= '0;
    end else if (cap_wr) begin
      if (slot == SLOT_ALO) addr_lo <= merge_bytes(addr_lo, cfg_wdata, ALO_WMASK, cfg_be);
      if (slot == SLOT_DATA) data_q <= merge_bytes({16'h0, data_q}, cfg_wdata, DATA_WMASK, cfg_be)[15:0];
    end
  end

  if (ADDR64) begin : g_ahi
    always_ff @(posedge clk) begin
      if (!rst_n) addr_hi <= '0;
      else if (cap_wr && slot == SLOT_AHI)
        addr_hi <= merge_bytes(addr_hi, cfg_wdata, 32'hFFFF_FFFF, cfg_be);
    end
  end else begin : g_noahi
    assign addr_hi = '0;
  end

  always_comb begin
    case (slot)
      SLOT_HDR:  rd_mux = hdr_dword;
      SLOT_ALO:  rd_mux = addr_lo;
      SLOT_AHI:  rd_mux = addr_hi;
      SLOT_DATA: rd_mux = {16'h0, data_q};
      SLOT_MASK: rd_mux = vec_mask;
      SLOT_PEND: rd_mux = vec_pending;
      default:   rd_mux = '0;
    endcase
  end

  assign cfg_rdata = cfg_rd ? rd_mux : '0;
  assign msg_addr  = {addr_hi, addr_lo};
  assign msg_data  = data_q;

  assert_alo_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00);
endmodule

// File: tb/msi_cap_regs_tb.sv
`timescale 1ns/1ps
module msi_cap_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [31:0] pend_set = '0, pend_clr = '0;
  logic        msi_enable, intx_deassert;
  logic [2:0]  vec_count_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask, vec_pending;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msi_cap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pend_set(pend_set), .pend_clr(pend_clr),
    .msi_enable(msi_enable), .vec_count_log2(vec_count_log2), .msg_addr(msg_addr),
    .msg_data(msg_data), .vec_mask(vec_mask), .vec_pending(vec_pending),
    .intx_deassert(intx_deassert)
  );

  // defaults: base dword 0x14, 64-bit, masking, 8 vectors (capable field 3)
  // dwords: 14 hdr, 15 addr lo, 16 addr hi, 17 data, 18 mask, 19 pending
  localparam int NT = 13;
  localparam logic [73:0] TBL [NT] = '{
    {6'h15, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFC}, // R3 addr low bits 1:0 zero
    {6'h16, 4'hF, 32'h1234_5678, 32'h1234_5678}, // R3 addr high
    {6'h17, 4'hF, 32'hABCD_1234, 32'h0000_1234}, // R3 data 16 bits
    {6'h17, 4'h2, 32'h0000_5500, 32'h0000_5534}, // R4 byte merge
    {6'h18, 4'hF, 32'hFFFF_FFFF, 32'h0000_00FF}, // R5 mask bits 0..7
    {6'h18, 4'h2, 32'h0000_0000, 32'h0000_00FF}, // R5 upper byte not writable
    {6'h14, 4'hC, 32'hFFFF_0000, 32'h01B7_0005}, // R6 clamp 7->3, R2 RO bits
    {6'h14, 4'h4, 32'h0000_0000, 32'h0186_0005}, // R2 disable, field 0
    {6'h14, 4'h4, 32'h0070_0000, 32'h01F6_0005}, // R6 no clamp when disabled
    {6'h19, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}, // R8 pending not writable
    {6'h14, 4'h1, 32'h0000_00FF, 32'h01F6_0005}, // R1 ID byte read-only
    {6'h1A, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}, // R10 past the span
    {6'h13, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}  // R10 below the span
  };
  string tags [NT] = '{"R3 alo", "R3 ahi", "R3 data", "R4 merge", "R5 mask",
                       "R5 mask hi", "R6 clamp", "R2 ctrl", "R6 noclamp",
                       "R8 pend ro", "R1 id", "R10 above", "R10 below"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be,
                           input logic [31:0] d, input logic [31:0] pset);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d; pend_set = pset;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; pend_set = '0;
  endtask

  task automatic pend_drive(input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = '0; pend_clr = '0;
  endtask

  task automatic cfg_read(input logic [5:0] dw, output logic [31:0] v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw_addr = dw;
    #1 v = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic check_reset_state();
    logic [31:0] v;
    cfg_read(6'h14, v);
    chk("R9 R1 R2 hdr after reset", {32'h0, v}, 64'h0186_0005);
    chk("R9 enable", {63'h0, msi_enable}, 64'h0);
    chk("R9 field", {61'h0, vec_count_log2}, 64'h0);
    chk("R9 addr", msg_addr, 64'h0);
    chk("R9 data", {48'h0, msg_data}, 64'h0);
    chk("R9 mask", {32'h0, vec_mask}, 64'h0);
    chk("R9 pending", {32'h0, vec_pending}, 64'h0);
    chk("R9 intx", {63'h0, intx_deassert}, 64'h0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < NT; i++) begin
      cfg_write(TBL[i][73:68], TBL[i][67:64], TBL[i][63:32], 32'h0);
      cfg_read(TBL[i][73:68], v);
      chk(tags[i], {32'h0, v}, {32'h0, TBL[i][31:0]});
    end

    chk("R12 msg_addr", msg_addr, 64'h1234_5678_FFFF_FFFC);
    chk("R12 msg_data", {48'h0, msg_data}, 64'h5534);
    chk("R12 field port", {61'h0, vec_count_log2}, 64'd7);
    chk("R12 enable port", {63'h0, msi_enable}, 64'h0);

    pend_drive(32'hFFFF_FFFF, 32'h0);
    chk("R8 set limited to N", {32'h0, vec_pending}, 64'hFF);
    pend_drive(32'h1, 32'h1);
    chk("R8 clear wins", {32'h0, vec_pending}, 64'hFE);

    // enable with 2 vectors: trim and pulse
    cfg_write(6'h14, 4'h4, 32'h0011_0000, 32'h0);
    chk("R7 pulse high", {63'h0, intx_deassert}, 64'h1);
    chk("R11 trim to 2 vectors", {32'h0, vec_pending}, 64'h02);
    chk("R12 field 1", {61'h0, vec_count_log2}, 64'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {63'h0, intx_deassert}, 64'h0);

    // same-cycle pend_set and trimming write
    cfg_write(6'h17, 4'h1, 32'h0000_0077, 32'h80);
    chk("R11 same-cycle set dropped", {32'h0, vec_pending}, 64'h02);
    chk("R7 pulse on data write", {63'h0, intx_deassert}, 64'h1);
    chk("R4 data byte0", {48'h0, msg_data}, 64'h5577);

    pend_drive(32'h80, 32'h0);
    chk("R8 set out of window", {32'h0, vec_pending}, 64'h82);
    cfg_write(6'h1A, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk("R10 no pulse outside", {63'h0, intx_deassert}, 64'h0);
    chk("R10 no trim outside", {32'h0, vec_pending}, 64'h82);
    cfg_write(6'h17, 4'h8, 32'hFF00_0000, 32'h0);
    chk("R10 reserved byte overlaps", {63'h0, intx_deassert}, 64'h1);
    chk("R11 trim on reserved byte", {32'h0, vec_pending}, 64'h02);
    chk("R3 data unchanged", {48'h0, msg_data}, 64'h5577);

    // disabling write: no pulse, no trim
    pend_drive(32'h80, 32'h0);
    cfg_write(6'h14, 4'h4, 32'h0, 32'h0);
    chk("R7 no pulse when disabled", {63'h0, intx_deassert}, 64'h0);
    chk("R11 no trim when disabled", {32'h0, vec_pending}, 64'h82);
    chk("R12 enable cleared", {63'h0, msi_enable}, 64'h0);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule